// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

The unit pulls a bit field out of a pair of data words, or merges a field into a word. A descriptor register holds the operation: a mode bit, a field width and a shift count. When an operation is accepted, the left and right words are joined as a double-width value with the left word on top. That value is shifted left by the shift count, and the upper word is kept.

In extract mode, the kept word is ANDed with a run of ones covering the low width bits. In insert mode, that run of ones is itself moved left by the shift count. Bits under the moved run take the shifted data, and all other bits keep the right word. Width and shift each range from 0 to the word width inclusive. A field value above the word width is treated as the word width when the descriptor is loaded.

Operands come in on a valid/ready stream and results leave on a valid/ready stream. There is one result register, so throughput is one result per cycle while the consumer keeps ready high. The input is accepted when `op_valid` and `op_ready` are both high. `op_ready` is high whenever the result register is empty or is being drained in the same cycle. While `res_valid` is high and `res_ready` is low, the result is held and no new operand is taken. The descriptor load is a plain control strobe with no handshake.

Top module: `fieldop_unit`

## Requirements
- R1: After reset, `res_valid` is low, `res_data` is zero and `op_ready` is high. The descriptor resets to extract mode with width 0 and shift 0, so a first operation yields zero.
- R2: The descriptor is 13 bits. Bit 12 is the mode (1 = insert), bits 11:6 are the field width and bits 5:0 are the shift count. It is written on a clock edge with `desc_we` high, and it governs every operation accepted after that edge.
- R3: In extract mode, the result is bits 63:32 of ({left, right} << shift) ANDed with a mask whose low width bits are ones.
- R4: In extract mode, a width of 0 gives zero. A width of 32 with a shift of 0 returns the left word unchanged.
- R5: In extract mode, a shift of 32 with a width of 32 returns the right word.
- R6: In insert mode, the mask of width ones is shifted left by the shift count and truncated to 32 bits. Result bits under that mask come from the shifted data, and all other result bits come from the right word.
- R7: A width or shift field above 32 behaves exactly as 32.
- R8: An accepted operation sets `res_valid` and loads `res_data` on the same clock edge.
- R9: While `res_valid` is high and `res_ready` is low, `res_data` and `res_valid` hold, `op_ready` is low, and a presented operand is not taken.
- R10: When `desc_we` and an accepted operation fall on the same edge, the operation uses the descriptor held before that edge. The new descriptor applies from the next operation on.
- R11: With `res_ready` held high, back-to-back operands are accepted one per cycle, and each result appears on the edge after its own acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_we | input | 1 | Load strobe for the descriptor register |
| desc_in | input | 13 | Descriptor value: mode, width, shift |
| op_valid | input | 1 | Operand pair is presented |
| op_ready | output | 1 | Unit can take the operand pair |
| left_in | input | 32 | Upper word of the double-width source |
| right_in | input | 32 | Lower word, and the base word for insert |
| res_valid | output | 1 | Result register holds a result |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 32 | Result word |

## Verification
Two things can happen on the same edge: a descriptor load and an operation acceptance. The bench loads one descriptor, then raises `desc_we` with a second descriptor in the same cycle that it presents an operand. It expects the result computed from the first descriptor, and it expects the next operation to follow the second. Output back-pressure is also combined with a waiting operand: the held result must not change, and the waiting operand must be taken on the very edge the consumer drains.

// File: rtl/fu_pkg.sv
package fu_pkg;
  typedef enum logic {FU_EXTRACT = 1'b0, FU_INSERT = 1'b1} fu_mode_e;

  function automatic int fu_sat(input int value, input int limit);
    return (value > limit) ? limit : value;
  endfunction
endpackage

// File: rtl/fu_desc_reg.sv
module fu_desc_reg
  import fu_pkg::*;
#(
  parameter int W = 32,
  localparam int FW = $clog2(W + 1),
  localparam int DW = 2 * FW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] din,
  output fu_mode_e      mode,
  output logic [FW-1:0] width,
  output logic [FW-1:0] shift
);
  logic [FW-1:0] w_raw, s_raw;
  assign w_raw = din[2*FW-1:FW];
  assign s_raw = din[FW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= FU_EXTRACT;
      width <= '0;
      shift <= '0;
    end else if (we) begin
      mode  <= din[DW-1] ? FU_INSERT : FU_EXTRACT;
      width <= FW'(fu_sat(int'(w_raw), W));
      shift <= FW'(fu_sat(int'(s_raw), W));
    end
  end
endmodule

// File: rtl/fu_funnel.sv
module fu_funnel #(
  parameter int W = 32,
  localparam int FW = $clog2(W + 1)
) (
  input  logic [W-1:0]  hi,
  input  logic [W-1:0]  lo,
  input  logic [FW-1:0] amt,
  output logic [W-1:0]  out
);
  logic [2*W-1:0] stage [FW];

  assign stage[0] = {hi, lo};

  for (genvar k = 0; k < FW - 1; k++) begin : g_stage
    assign stage[k+1] = amt[k] ? (stage[k] << (2 ** k)) : stage[k];
  end

  localparam int LAST = 2 ** (FW - 1);
  assign out = amt[FW-1] ? stage[FW-1][2*W-1-LAST -: W] : stage[FW-1][2*W-1 -: W];
endmodule

// File: rtl/fu_maskgen.sv
module fu_maskgen #(
  parameter int W = 32,
  localparam int FW = $clog2(W + 1)
) (
  input  logic [FW-1:0] width,
  input  logic [FW-1:0] shift,
  output logic [W-1:0]  low_mask,
  output logic [W-1:0]  placed_mask
);
  logic [FW:0] w_ext, s_ext, top;
  assign w_ext = {1'b0, width};
  assign s_ext = {1'b0, shift};
  assign top   = s_ext + w_ext;

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [FW:0] IDX = (FW + 1)'(i);
    assign low_mask[i]    = IDX < w_ext;
    assign placed_mask[i] = (IDX >= s_ext) && (IDX < top);
  end
endmodule

// File: rtl/fu_outstage.sv
module fu_outstage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/fieldop_unit.sv
module fieldop_unit
  import fu_pkg::*;
#(
  parameter int W = 32,
  localparam int FW = $clog2(W + 1),
  localparam int DW = 2 * FW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_we,
  input  logic [DW-1:0] desc_in,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [W-1:0]  left_in,
  input  logic [W-1:0]  right_in,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [W-1:0]  res_data
);
  fu_mode_e      d_mode;
  logic [FW-1:0] d_width, d_shift;
  logic [W-1:0]  shifted, low_mask, placed_mask, next_res;

  fu_desc_reg #(.W(W)) u_desc (
    .clk(clk), .rst_n(rst_n), .we(desc_we), .din(desc_in),
    .mode(d_mode), .width(d_width), .shift(d_shift)
  );

  fu_funnel #(.W(W)) u_funnel (
    .hi(left_in), .lo(right_in), .amt(d_shift), .out(shifted)
  );

  fu_maskgen #(.W(W)) u_mask (
    .width(d_width), .shift(d_shift),
    .low_mask(low_mask), .placed_mask(placed_mask)
  );

  always_comb begin
    if (d_mode == FU_INSERT) next_res = (shifted & placed_mask) | (right_in & ~placed_mask);
    else                     next_res = shifted & low_mask;
  end

  fu_outstage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(op_valid), .in_ready(op_ready), .in_data(next_res),
    .out_valid(res_valid), .out_ready(res_ready), .out_data(res_data)
  );
endmodule

// File: rtl/fieldop_unit_chk.sv
module fieldop_unit_chk #(
  parameter int W = 32,
  localparam int FW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic          op_ready,
  input logic [W-1:0]  left_in,
  input logic [W-1:0]  right_in,
  input logic          res_valid,
  input logic          res_ready,
  input logic [W-1:0]  res_data,
  input logic          d_ins,
  input logic [FW-1:0] d_width,
  input logic [FW-1:0] d_shift
);
  localparam logic [FW-1:0] FULL = FW'(W);

  // R8
  accept_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> res_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !op_ready);

  // R4
  zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !d_ins && d_width == '0) |=> (res_data == '0));

  // R4
  left_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !d_ins && d_width == FULL && d_shift == '0)
      |=> (res_data == $past(left_in)));

  // R5
  right_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !d_ins && d_width == FULL && d_shift == FULL)
      |=> (res_data == $past(right_in)));

  // R7
  desc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_width <= FULL) && (d_shift <= FULL));
endmodule

bind fieldop_unit fieldop_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .left_in(left_in), .right_in(right_in), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data), .d_ins(d_mode == fu_pkg::FU_INSERT),
  .d_width(d_width), .d_shift(d_shift)
);

// File: tb/sim_fieldop_unit.sv
`timescale 1ns/1ps
module sim_fieldop_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_we = 1'b0;
  logic [12:0] desc_in = '0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [31:0] left_in = '0, right_in = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_data;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fieldop_unit u0 (.*);

  function automatic logic [31:0] model(bit ins, int m, int s, logic [31:0] l, logic [31:0] r);
    logic [63:0] cat, lm, pm;
    logic [31:0] data;
    if (m > 32) m = 32;
    if (s > 32) s = 32;
    cat  = {l, r} << s;
    data = cat[63:32];
    lm   = (m == 0) ? 64'd0 : ((64'd1 << m) - 64'd1);
    pm   = lm << s;
    return ins ? ((data & pm[31:0]) | (r & ~pm[31:0])) : (data & lm[31:0]);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_desc(bit ins, int m, int s);
    @(negedge clk);
    desc_we = 1'b1;
    desc_in = {ins, 6'(m), 6'(s)};
    @(negedge clk);
    desc_we = 1'b0;
  endtask

  task automatic op_chk(string tag, bit ins, int m, int s, logic [31:0] l, logic [31:0] r);
    @(negedge clk);
    op_valid = 1'b1; left_in = l; right_in = r;
    @(negedge clk);
    op_valid = 1'b0;
    chk({tag, " valid"}, 32'(res_valid), 32'd1);
    chk(tag, res_data, model(ins, m, s, l, r));
  endtask

  task automatic t_reset();
    chk("R1 res_valid", 32'(res_valid), 32'd0);
    chk("R1 res_data", res_data, 32'd0);
    chk("R1 op_ready", 32'(op_ready), 32'd1);
    op_chk("R1 reset descriptor", 1'b0, 0, 0, 32'hDEADBEEF, 32'h12345678);
  endtask

  task automatic t_extract();
    for (int s = 0; s <= 32; s++) begin
      set_desc(1'b0, 32, s);
      op_chk("R3 shift sweep", 1'b0, 32, s, 32'hF0402010, 32'hAAAAAAAA);
    end
    for (int m = 0; m <= 32; m++) begin
      set_desc(1'b0, m, 0);
      op_chk("R4 width sweep", 1'b0, m, 0, 32'hF0402010, 32'hAAAAAAAA);
    end
    for (int i = 0; i <= 32; i++) begin
      set_desc(1'b0, (4 * i + 19) % 33, (3 * i + 5) % 33);
      op_chk("R3 mixed", 1'b0, (4 * i + 19) % 33, (3 * i + 5) % 33, 32'hF0402010, 32'h2BAD2BAD);
    end
    set_desc(1'b0, 32, 32);
    op_chk("R5 right word", 1'b0, 32, 32, 32'h00137FFF, 32'hFEC80000);
    set_desc(1'b0, 0, 17);
    op_chk("R4 zero width", 1'b0, 0, 17, 32'hFFFFFFFF, 32'hFFFFFFFF);
  endtask

  task automatic t_insert();
    set_desc(1'b1, 0, 0);
    op_chk("R6 empty field", 1'b1, 0, 0, 32'hF0402010, 32'h2BAD2BAD);
    set_desc(1'b1, 32, 0);
    op_chk("R6 full field", 1'b1, 32, 0, 32'hF0402010, 32'h2BAD2BAD);
    set_desc(1'b1, 32, 32);
    op_chk("R6 field off top", 1'b1, 32, 32, 32'hF0402010, 32'h2BAD2BAD);
    set_desc(1'b1, 18, 4);
    op_chk("R6 mid field", 1'b1, 18, 4, 32'hF0402010, 32'hAAAAAAAA);
    set_desc(1'b1, 21, 12);
    op_chk("R6 truncated field", 1'b1, 21, 12, 32'hF0402010, 32'h2BAD2BAD);
    set_desc(1'b1, 8, 8);
    op_chk("R2 insert bit layout", 1'b1, 8, 8, 32'h000000A5, 32'h11111111);
  endtask

  task automatic t_clamp();
    set_desc(1'b0, 63, 63);
    op_chk("R7 both clamp", 1'b0, 32, 32, 32'h01234567, 32'h89ABCDEF);
    set_desc(1'b0, 40, 5);
    op_chk("R7 width clamp", 1'b0, 32, 5, 32'h01234567, 32'h89ABCDEF);
    set_desc(1'b1, 12, 50);
    op_chk("R7 shift clamp insert", 1'b1, 12, 32, 32'h01234567, 32'h89ABCDEF);
  endtask

  task automatic t_backpressure();
    logic [31:0] a;
    logic [31:0] b;
    set_desc(1'b0, 16, 8);
    a = model(1'b0, 16, 8, 32'h11223344, 32'h55667788);
    b = model(1'b0, 16, 8, 32'hCAFEF00D, 32'h0BADBEEF);
    @(negedge clk);
    res_ready = 1'b0; op_valid = 1'b1; left_in = 32'h11223344; right_in = 32'h55667788;
    @(negedge clk);
    chk("R9 first result", res_data, a);
    chk("R9 op_ready low", 32'(op_ready), 32'd0);
    left_in = 32'hCAFEF00D; right_in = 32'h0BADBEEF;
    @(negedge clk);
    chk("R9 held result", res_data, a);
    chk("R9 held valid", 32'(res_valid), 32'd1);
    res_ready = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R9 waiting operand taken", res_data, b);
    @(negedge clk);
    chk("R8 drained", 32'(res_valid), 32'd0);
  endtask

  task automatic t_same_cycle();
    set_desc(1'b0, 8, 0);
    @(negedge clk);
    desc_we = 1'b1; desc_in = {1'b1, 6'd4, 6'd4};
    op_valid = 1'b1; left_in = 32'h0000000F; right_in = 32'hFFFF0000;
    @(negedge clk);
    desc_we = 1'b0; op_valid = 1'b0;
    chk("R10 old descriptor", res_data, model(1'b0, 8, 0, 32'h0000000F, 32'hFFFF0000));
    op_chk("R10 new descriptor", 1'b1, 4, 4, 32'h0000000F, 32'hFFFF0000);
  endtask

  task automatic t_stream();
    logic [31:0] l;
    set_desc(1'b0, 12, 20);
    @(negedge clk);
    op_valid = 1'b1; left_in = 32'h10000000; right_in = 32'h00000001;
    for (int i = 1; i <= 4; i++) begin
      l = left_in;
      @(negedge clk);
      chk("R11 one per cycle ready", 32'(op_ready), 32'd1);
      chk("R11 back-to-back", res_data, model(1'b0, 12, 20, l, 32'h00000001));
      left_in = l + 32'h01010101 * 32'(i);
    end
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_extract();
    t_insert();
    t_clamp();
    t_backpressure();
    t_same_cycle();
    t_stream();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule